// File: doc/BRIEF.md
# Serial ADC Capture Sequencer

This block paces a 10-bit ADC that has a serial output, and turns the ADC's serial bit stream into a parallel word. A loadable 4-bit up-counter sets the conversion period. On every rising edge it counts from a programmable start value up to its all-ones terminal count, then reloads. The cycle at terminal count is the single event that frames each conversion. It drives an active-low chip-select / start-convert pulse for the ADC, the counter reload, and the latch of the parallel output register.

The serial data bit is sampled on every system clock edge and shifted into a 16-bit path made of two cascaded 8-bit stages. The serial clock runs at the system clock rate; the block brings out a run-enable that lets the clock be gated at chip level. Each stage has its own output register that changes only on the terminal-count latch. The published word is the ten most recently sampled bits, oldest bit in the most significant position. High-impedance or idle bits that precede the data window fall out of the word. A one-cycle valid strobe marks each new word.

A chip uses it by tying the start count to a constant or a configuration field. It routes the chip select and the gated serial clock to the converter, and takes `wordOut` when `wordValid` pulses. A start count of 1 gives one conversion every 15 clocks.

Top module: `adc_capture_seq`

## Requirements
- R1: Outside reset the counter advances by one on each rising edge from the start count up to 15, so the period between conversions is 16 minus the start count in clocks (15 clocks for start count 1, 16 for start count 0, 1 for start count 15).
- R2: When the counter is at 15 it reloads the start count on the next edge. `startCount` is read only at that reload and during reset, so a change made in mid-period takes effect only from the next period boundary.
- R3: `chipSelN` is low for exactly the one cycle that follows each terminal-count cycle and high in all other cycles.
- R4: `serData` is sampled on every rising edge outside reset into a 16-bit shift path, entering at bit 0 and moving toward bit 15. The bit that arrived first of any ten ends up in `wordOut[9]` and the last in `wordOut[0]`.
- R5: On the terminal-count edge, `wordOut` takes the ten bits sampled on the last ten edges, including that edge. Bits sampled before those ten, such as idle or high-impedance bits ahead of the data window, do not appear in the word.
- R6: `wordValid` is high for one cycle, in the same cycle as `chipSelN` is low, and `wordOut` changes only in such a cycle. Between latches `wordOut` holds its value whatever arrives on `serData`.
- R7: Synchronous active-high reset loads the counter with `startCount`, forces `chipSelN` high and clears `wordOut`, `wordValid`, `sclkRun` and the shift path.
- R8: `sclkRun`, the serial clock run-enable, is low in the cycle after a reset edge and high in every cycle after a clock edge without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| startCount | input | 4 | Counter reload value that sets the conversion period |
| serData | input | 1 | Serial data bit from the ADC, most significant bit first |
| chipSelN | output | 1 | Active-low chip select / start convert, one cycle per period |
| sclkRun | output | 1 | Run-enable for gating the serial clock at chip level |
| wordOut | output | 10 | Latched parallel conversion word |
| wordValid | output | 1 | One-cycle strobe marking a new `wordOut` |

## Verification
The bench builds the block with its default values: a 4-bit counter, a 10-bit word and 8-bit stages. These defaults reach both period extremes, a reload every cycle at start count 15 and a full 16-cycle sweep at start count 0. They also give a two-stage cascade whose upper stage holds only two word bits, so the stage boundary and the bits dropped above it are both exercised. Random start counts and serial data run alongside directed cases: a known pattern that follows idle bits, a start change in mid-period, and a reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Strobes the sequencing control hands to the capture datapath.
  typedef struct packed {
    logic shiftEn;  // serial clock running: shift one bit in
    logic latchEn;  // terminal count: update the output stages
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] startCount,
  output seqStrobe_t       strobes,
  output logic             chipSelN,
  output logic             sclkRun
);

  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             termHit;

  assign termHit = (cnt == TERM);

  // Loadable period counter: reloads the start value after terminal count.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= startCount;
    end else if (termHit) begin
      cnt <= startCount;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Chip select and run-enable, registered so they leave the block glitch-free.
  always_ff @(posedge clk) begin
    if (rst) begin
      chipSelN <= 1'b1;
      sclkRun  <= 1'b0;
    end else begin
      chipSelN <= ~termHit;
      sclkRun  <= 1'b1;
    end
  end

  assign strobes.shiftEn = ~rst;
  assign strobes.latchEn = termHit & ~rst;

  // R1: counter steps by one away from terminal count
  p_count_up_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt != TERM) |=> (cnt == $past(cnt) + 1'b1));

  // R2: terminal count reloads the value present at that edge
  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt == TERM) |=> (cnt == $past(startCount)));

  // R3: an active select always coincides with a freshly reloaded counter
  p_sel_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (!chipSelN && !$past(rst)) |-> (cnt == $past(startCount)));

  // R7, R8: reset releases select and stops the serial clock
  p_reset_ctrl_r7: assert property (@(posedge clk)
    rst |=> (chipSelN && !sclkRun));

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int STAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobes,
  input  logic              serData,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid
);

  localparam int NUM_STAGES = (DATA_W + STAGE_W - 1) / STAGE_W;
  localparam int SHIFT_W    = NUM_STAGES * STAGE_W;

  logic [SHIFT_W-1:0] shiftPath;
  logic [SHIFT_W-1:0] shiftNext;

  // Newest bit enters at bit 0; stages cascade upward.
  assign shiftNext = {shiftPath[SHIFT_W-2:0], serData};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftPath <= '0;
    end else if (strobes.shiftEn) begin
      shiftPath <= shiftNext;
    end
  end

  // One output register per stage, holding only the bits the word uses.
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    localparam int REM   = DATA_W - g * STAGE_W;
    localparam int HOLDW = (REM < STAGE_W) ? REM : STAGE_W;
    logic [HOLDW-1:0] heldQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        heldQ <= '0;
      end else if (strobes.latchEn) begin
        heldQ <= shiftNext[g*STAGE_W +: HOLDW];
      end
    end

    assign wordOut[g*STAGE_W +: HOLDW] = heldQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordValid <= 1'b0;
    end else begin
      wordValid <= strobes.latchEn;
    end
  end

  // R4: every bit advances one place per serial clock
  p_shift_order_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |=> (shiftPath[SHIFT_W-1:1] == $past(shiftPath[SHIFT_W-2:0])));

  // R5: a new word equals the ten youngest bits of the shift path
  p_word_window_r5: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> (wordOut == shiftPath[DATA_W-1:0]));

  // R6: the word holds between latch strobes
  p_word_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!wordValid && !$past(rst)) |-> $stable(wordOut));

  // R7: reset clears the published word and strobe
  p_reset_dp_r7: assert property (@(posedge clk)
    rst |=> ((wordOut == '0) && !wordValid));

endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_seq_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int DATA_W  = 10,
  parameter int STAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  startCount,
  input  logic              serData,
  output logic              chipSelN,
  output logic              sclkRun,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid
);

  seqStrobe_t strobes;

  adc_seq_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startCount(startCount),
    .strobes   (strobes),
    .chipSelN  (chipSelN),
    .sclkRun   (sclkRun)
  );

  adc_seq_dp #(
    .DATA_W (DATA_W),
    .STAGE_W(STAGE_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .serData  (serData),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

  // R3, R6: select and valid strobe mark the same cycle
  p_frame_align_r6: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> !chipSelN);

endmodule

// File: tb/adc_capture_seq_tb.sv
`timescale 1ns/1ps
module adc_capture_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] startCount = 4'd1;
  logic       serData = 1'b0;
  logic       chipSelN;
  logic       sclkRun;
  logic [9:0] wordOut;
  logic       wordValid;

  int total = 0;
  int bad   = 0;
  bit randData = 1'b1;
  bit modelOn  = 1'b0;

  always #2 clk = ~clk;

  adc_capture_seq u_dut (
    .clk(clk), .rst(rst), .startCount(startCount), .serData(serData),
    .chipSelN(chipSelN), .sclkRun(sclkRun), .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int periodOf(input logic [3:0] s);
    return 16 - int'(s);
  endfunction

  // Reference model built from the requirements.
  logic [3:0]  mCnt;
  logic [15:0] mHist;
  logic [9:0]  mWord;
  logic        mSel, mVal, mRun, mInRst;

  always @(posedge clk) begin
    if (rst) begin
      mCnt = startCount; mHist = '0; mWord = '0;
      mSel = 1'b1; mVal = 1'b0; mRun = 1'b0; mInRst = 1'b1;
    end else begin
      mInRst = 1'b0; mRun = 1'b1;
      mHist = {mHist[14:0], serData};
      if (mCnt == 4'hF) begin
        mWord = mHist[9:0]; mVal = 1'b1; mSel = 1'b0; mCnt = startCount;
      end else begin
        mVal = 1'b0; mSel = 1'b1; mCnt = mCnt + 4'd1;
      end
    end
    modelOn = 1'b1;
  end

  always @(negedge clk) begin
    if (modelOn) begin
      if (mInRst) begin
        chk("R7 select", chipSelN, mSel);
        chk("R7 word", wordOut, mWord);
        chk("R7 valid", wordValid, mVal);
        chk("R7 run", sclkRun, mRun);
      end else begin
        chk("R3 select", chipSelN, mSel);
        chk("R5 word", wordOut, mWord);
        chk("R6 valid", wordValid, mVal);
        chk("R8 run", sclkRun, mRun);
      end
    end
    if (randData) serData = 1'($urandom_range(0, 1));
  end

  task automatic waitSel();
    do @(negedge clk); while (chipSelN);
  endtask

  task automatic gapCount(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (chipSelN);
  endtask

  initial begin
    int gap;
    logic [9:0] pat;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: default start value gives a 15-clock period
    waitSel();
    gapCount(gap); chk("R1 period start=1", gap, 15);
    gapCount(gap); chk("R1 period start=1 again", gap, 15);

    // R4, R5: idle bits then a known pattern, MSB first
    randData = 1'b0;
    pat = 10'h2A5;
    waitSel();
    for (int i = 0; i < 15; i++) begin
      serData = (i < 5) ? 1'b1 : pat[14 - i];
      @(negedge clk);
    end
    chk("R5 valid after pattern", wordValid, 1);
    chk("R4 pattern order, idle dropped", wordOut, pat);
    // R6: word holds while data toggles
    for (int i = 0; i < 10; i++) begin
      serData = ~serData;
      @(negedge clk);
    end
    chk("R6 word held", wordOut, pat);
    randData = 1'b1;

    // R2: mid-period start change applies only after the boundary
    waitSel();
    repeat (3) @(negedge clk);
    startCount = 4'd6;
    gap = 3;
    begin
      int more;
      gapCount(more);
      chk("R2 old period kept", gap + more, 15);
    end
    gapCount(gap); chk("R2 new period", gap, periodOf(4'd6));

    // R1: extremes
    startCount = 4'd0;
    waitSel(); waitSel();
    gapCount(gap); chk("R1 period start=0", gap, 16);
    startCount = 4'd15;
    waitSel(); waitSel();
    gapCount(gap); chk("R1 period start=15", gap, 1);

    // Random start counts with random data
    for (int k = 0; k < 40; k++) begin
      startCount = 4'($urandom_range(0, 15));
      repeat ($urandom_range(20, 120)) @(negedge clk);
    end

    // R7: mid-run reset
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 select high in reset", chipSelN, 1);
    chk("R7 word cleared", wordOut, 0);
    chk("R8 run low in reset", sclkRun, 0);
    startCount = 4'd1;
    rst = 1'b0;
    @(negedge clk);
    chk("R8 run after release", sclkRun, 1);
    waitSel();
    gapCount(gap); chk("R1 period after reset", gap, 15);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule